// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sequences trap entry and trap return for a small 32-bit soft processor core. The pipeline presents raw fault conditions: a breakpoint, an unmapped or misaligned data access, a system call, and a divide or modulo operation together with its divisor value. In a given cycle the block picks at most one accepted trap. For that trap it produces a registered redirect to the handler address and a registered write strobe that places the faulting instruction address into a link general register. The core's register file performs the write.

The block owns four control registers: the interrupt-enable word (three bits), the interrupt-pending word, the ordinary-trap base address and the debug-trap base address. Ordinary traps link through register 30 and debug breakpoints link through register 31. Each kind saves the live enable bit into its own slot of the enable word. An indirect branch through register 30 or register 31 is reported to the block as a return. The block then restores the matching saved bit and redirects to the branch target. Software reads the control registers through the exposed outputs and writes them through a simple write port.

Top module: `exc_seq`

## Requirements
- R1: A synchronous active-high reset sets the enable, pending and both base registers to zero and clears redirect_valid and gpr_we.
- R2: An accepted ordinary trap (divide by zero, system call, data bus error) asserts gpr_we one cycle later, with gpr_waddr = 30 and gpr_wdata = the fault_pc of the request cycle.
- R3: An accepted breakpoint asserts gpr_we one cycle later, with gpr_waddr = 31 and gpr_wdata = fault_pc.
- R4: On ordinary trap entry the enable word becomes {0, old bit0, 0}, with bit 2 as the leftmost bit.
- R5: On breakpoint entry the enable word becomes {old bit0, 0, 0}.
- R6: The handler address is the ordinary base plus 32 times the trap ID. For a breakpoint it is the debug base plus 32. The trap IDs are: breakpoint 1, data bus error 4, divide by zero 5, system call 7.
- R7: When several trap requests are present in one cycle, the lowest ID is accepted and only that one trap takes effect.
- R8: A return (ret_valid with no trap accepted) redirects to ret_target one cycle later and writes no register. The enable word changes as follows: through register 30 it becomes {0, 0, old bit1}; through register 31 it becomes {0, 0, old bit2}; through any other register it is unchanged.
- R9: A write to the pending register (csr_sel = 1) clears each bit written as one and keeps each bit written as zero. Bits on irq_set become pending, and a set wins over a clear in the same cycle.
- R10: csr_sel selects the register: 0 enable (data bits 2:0), 2 ordinary base, 3 debug base. A write replaces the register contents, but the low 8 bits of both base registers always read as zero.
- R11: A divide with a zero divisor (div_valid with div_divisor = 0) raises divide by zero. With a nonzero divisor the block produces no redirect and no register write.
- R12: An unmapped access and a misaligned access both take the data-bus-error handler (ID 4).
- R13: An accepted trap ignores a same-cycle return. An enable-register write is ignored in any cycle in which a trap or a return through register 30 or 31 changes the enable word.
- R14: redirect_valid is high for exactly one cycle per accepted trap or return, and is low in the following cycle unless a new event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_brk | input | 1 | Breakpoint request |
| req_unmapped | input | 1 | Data access to an unmapped address |
| req_misalign | input | 1 | Misaligned data access |
| req_scall | input | 1 | System call request |
| div_valid | input | 1 | Divide or modulo operation issued |
| div_divisor | input | 32 | Divisor value of that operation |
| fault_pc | input | 32 | Address of the requesting instruction |
| ret_valid | input | 1 | Indirect branch issued (return candidate) |
| ret_reg | input | 5 | Register index the branch goes through |
| ret_target | input | 32 | Branch target address |
| csr_we | input | 1 | Control register write strobe |
| csr_sel | input | 2 | Control register select |
| csr_wdata | input | 32 | Control register write data |
| irq_set | input | 8 | Interrupt lines that set pending bits |
| redirect_valid | output | 1 | Registered one-cycle redirect pulse |
| redirect_pc | output | 32 | Registered redirect target |
| gpr_we | output | 1 | Link register write strobe |
| gpr_waddr | output | 5 | Link register index |
| gpr_wdata | output | 32 | Saved fault address |
| csr_ie | output | 3 | Enable word |
| csr_ip | output | 8 | Pending word |
| csr_eba | output | 32 | Ordinary trap base |
| csr_deba | output | 32 | Debug trap base |

## Verification
The bench sweeps every combination of the five trap sources with both values of the live enable bit. Each time it computes the winning ID, the handler address, the link register and the new enable word. A wrong priority order would vector to the wrong handler, and mixing up the two base registers would put breakpoints at an ordinary offset. Returns are swept over all eight enable words and through registers 29, 30 and 31, which exposes a swapped restore slot. Pending-bit tests cover write-one-to-clear, zero writes and a set colliding with a clear. The collision tests also check that a trap overrides a return and that an enable write cannot undo an entry.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        EID_RESET = 3'd0,
        EID_BRK   = 3'd1,
        EID_IBUS  = 3'd2,
        EID_WATCH = 3'd3,
        EID_DBUS  = 3'd4,
        EID_DIV0  = 3'd5,
        EID_IRQ   = 3'd6,
        EID_SCALL = 3'd7
    } exc_id_e;

    typedef enum logic [1:0] {
        CSR_IE   = 2'd0,
        CSR_IP   = 2'd1,
        CSR_EBA  = 2'd2,
        CSR_DEBA = 2'd3
    } csr_sel_e;

    typedef enum logic [2:0] {
        IE_HOLD,
        IE_ENTER_EXC,
        IE_ENTER_BRK,
        IE_RET_EXC,
        IE_RET_BRK
    } ie_mode_e;

    localparam int unsigned N_ID   = 8;
    localparam int unsigned IE_W   = 3;
    localparam logic [4:0]  LINK_EXC = 5'd30;
    localparam logic [4:0]  LINK_BRK = 5'd31;

endpackage

// File: rtl/exc_arb.sv
module exc_arb #(
    parameter int unsigned N    = 8,
    localparam int unsigned ID_W = $clog2(N)
) (
    input  logic [N-1:0]    req,
    output logic            hit,
    output logic [ID_W-1:0] id
);
    always_comb begin
        hit = 1'b0;
        id  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                id  = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/exc_ie_next.sv
module exc_ie_next
    import exc_pkg::*;
(
    input  ie_mode_e        mode,
    input  logic [IE_W-1:0] ie_q,
    output logic [IE_W-1:0] ie_d
);
    always_comb begin
        unique case (mode)
            IE_ENTER_EXC: ie_d = {1'b0, ie_q[0], 1'b0};
            IE_ENTER_BRK: ie_d = {ie_q[0], 2'b00};
            IE_RET_EXC:   ie_d = {2'b00, ie_q[1]};
            IE_RET_BRK:   ie_d = {2'b00, ie_q[2]};
            default:      ie_d = ie_q;
        endcase
    end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned IP_W      = 8,
    parameter int unsigned BASE_LSB  = 8,
    parameter int unsigned VEC_SHIFT = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_brk,
    input  logic            req_unmapped,
    input  logic            req_misalign,
    input  logic            req_scall,
    input  logic            div_valid,
    input  logic [XLEN-1:0] div_divisor,
    input  logic [XLEN-1:0] fault_pc,
    input  logic            ret_valid,
    input  logic [4:0]      ret_reg,
    input  logic [XLEN-1:0] ret_target,
    input  logic            csr_we,
    input  logic [1:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [IP_W-1:0] irq_set,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic            gpr_we,
    output logic [4:0]      gpr_waddr,
    output logic [XLEN-1:0] gpr_wdata,
    output logic [IE_W-1:0] csr_ie,
    output logic [IP_W-1:0] csr_ip,
    output logic [XLEN-1:0] csr_eba,
    output logic [XLEN-1:0] csr_deba
);
    localparam int unsigned ID_W = $clog2(N_ID);

    typedef struct packed {
        logic [IE_W-1:0] ie;
        logic [IP_W-1:0] ip;
        logic [XLEN-1:0] eba;
        logic [XLEN-1:0] deba;
        logic            rv;
        logic [XLEN-1:0] rpc;
        logic            gwe;
        logic [4:0]      gwa;
        logic [XLEN-1:0] gwd;
    } state_t;

    state_t st_d, st_q;

    logic [N_ID-1:0] req_vec;
    logic            arb_hit;
    logic [ID_W-1:0] arb_id;
    ie_mode_e        ie_mode;
    logic [IE_W-1:0] ie_next;

    always_comb begin
        req_vec                    = '0;
        req_vec[int'(EID_BRK)]     = req_brk;
        req_vec[int'(EID_DBUS)]    = req_unmapped | req_misalign;
        req_vec[int'(EID_DIV0)]    = div_valid && (div_divisor == '0);
        req_vec[int'(EID_SCALL)]   = req_scall;
    end

    exc_arb #(.N(N_ID)) u_arb (
        .req (req_vec),
        .hit (arb_hit),
        .id  (arb_id)
    );

    always_comb begin
        ie_mode = IE_HOLD;
        if (arb_hit) begin
            ie_mode = (arb_id == ID_W'(EID_BRK)) ? IE_ENTER_BRK : IE_ENTER_EXC;
        end else if (ret_valid) begin
            if (ret_reg == LINK_EXC)      ie_mode = IE_RET_EXC;
            else if (ret_reg == LINK_BRK) ie_mode = IE_RET_BRK;
        end
    end

    exc_ie_next u_ie (
        .mode (ie_mode),
        .ie_q (st_q.ie),
        .ie_d (ie_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rv  = 1'b0;
        st_d.rpc = '0;
        st_d.gwe = 1'b0;
        st_d.gwa = '0;
        st_d.gwd = '0;

        if (arb_hit) begin
            st_d.rv  = 1'b1;
            st_d.gwe = 1'b1;
            st_d.gwd = fault_pc;
            if (arb_id == ID_W'(EID_BRK)) begin
                st_d.gwa = LINK_BRK;
                st_d.rpc = st_q.deba + (XLEN'(arb_id) << VEC_SHIFT);
            end else begin
                st_d.gwa = LINK_EXC;
                st_d.rpc = st_q.eba + (XLEN'(arb_id) << VEC_SHIFT);
            end
        end else if (ret_valid) begin
            st_d.rv  = 1'b1;
            st_d.rpc = ret_target;
        end

        st_d.ie = ie_next;

        if (csr_we) begin
            unique case (csr_sel_e'(csr_sel))
                CSR_IE: begin
                    if (ie_mode == IE_HOLD) st_d.ie = csr_wdata[IE_W-1:0];
                end
                CSR_IP:   st_d.ip   = st_q.ip & ~csr_wdata[IP_W-1:0];
                CSR_EBA:  st_d.eba  = {csr_wdata[XLEN-1:BASE_LSB], {BASE_LSB{1'b0}}};
                CSR_DEBA: st_d.deba = {csr_wdata[XLEN-1:BASE_LSB], {BASE_LSB{1'b0}}};
                default: ;
            endcase
        end

        st_d.ip = st_d.ip | irq_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_valid = st_q.rv;
    assign redirect_pc    = st_q.rpc;
    assign gpr_we         = st_q.gwe;
    assign gpr_waddr      = st_q.gwa;
    assign gpr_wdata      = st_q.gwd;
    assign csr_ie         = st_q.ie;
    assign csr_ip         = st_q.ip;
    assign csr_eba        = st_q.eba;
    assign csr_deba       = st_q.deba;

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned IP_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            req_brk,
    input logic            req_unmapped,
    input logic            req_misalign,
    input logic            req_scall,
    input logic            div_valid,
    input logic [XLEN-1:0] div_divisor,
    input logic [XLEN-1:0] fault_pc,
    input logic            ret_valid,
    input logic [XLEN-1:0] ret_target,
    input logic            csr_we,
    input logic [1:0]      csr_sel,
    input logic [XLEN-1:0] csr_wdata,
    input logic [IP_W-1:0] irq_set,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic            gpr_we,
    input logic [4:0]      gpr_waddr,
    input logic [XLEN-1:0] gpr_wdata,
    input logic [2:0]      csr_ie,
    input logic [IP_W-1:0] csr_ip,
    input logic [XLEN-1:0] csr_eba,
    input logic [XLEN-1:0] csr_deba
);
    logic any_ord;
    logic any_exc;
    assign any_ord = req_unmapped | req_misalign | req_scall | (div_valid && div_divisor == '0);
    assign any_exc = any_ord | req_brk;

    p_link_pc_r2: assert property (@(posedge clk) disable iff (rst)
        gpr_we |-> (gpr_wdata == $past(fault_pc)) && redirect_valid);

    p_brk_entry_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && req_brk) |-> (csr_ie == {$past(csr_ie[0]), 2'b00}) && gpr_waddr == 5'd31);

    p_exc_entry_r4: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && any_ord && !req_brk) |-> (csr_ie == {1'b0, $past(csr_ie[0]), 1'b0}) && gpr_waddr == 5'd30);

    p_ip_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && csr_we && csr_sel == 2'd1) |->
            ((csr_ip & ~$past(irq_set)) == ($past(csr_ip) & ~$past(csr_wdata[IP_W-1:0]) & ~$past(irq_set))));

    p_ret_target_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && ret_valid && !any_exc) |-> redirect_valid && !gpr_we && redirect_pc == $past(ret_target));

    p_pulse_cause_r14: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> $past(!rst && (any_exc || ret_valid)));

    p_base_align_r10: assert property (@(posedge clk) disable iff (rst)
        (csr_eba[7:0] == 8'd0) && (csr_deba[7:0] == 8'd0));

endmodule

bind exc_seq exc_seq_chk #(.XLEN(XLEN), .IP_W(IP_W)) u_chk (
    .clk(clk), .rst(rst), .req_brk(req_brk), .req_unmapped(req_unmapped),
    .req_misalign(req_misalign), .req_scall(req_scall), .div_valid(div_valid),
    .div_divisor(div_divisor), .fault_pc(fault_pc), .ret_valid(ret_valid),
    .ret_target(ret_target), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .irq_set(irq_set), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr),
    .gpr_wdata(gpr_wdata), .csr_ie(csr_ie), .csr_ip(csr_ip),
    .csr_eba(csr_eba), .csr_deba(csr_deba)
);

// File: tb/sim_exc_seq.sv
`timescale 1ns/1ps
module sim_exc_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_brk, req_unmapped, req_misalign, req_scall, div_valid;
    logic [31:0] div_divisor, fault_pc, ret_target, csr_wdata;
    logic        ret_valid, csr_we;
    logic [4:0]  ret_reg;
    logic [1:0]  csr_sel;
    logic [7:0]  irq_set;
    logic        redirect_valid, gpr_we;
    logic [31:0] redirect_pc, gpr_wdata, csr_eba, csr_deba;
    logic [4:0]  gpr_waddr;
    logic [2:0]  csr_ie;
    logic [7:0]  csr_ip;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_seq u0 (
        .clk(clk), .rst(rst), .req_brk(req_brk), .req_unmapped(req_unmapped),
        .req_misalign(req_misalign), .req_scall(req_scall), .div_valid(div_valid),
        .div_divisor(div_divisor), .fault_pc(fault_pc), .ret_valid(ret_valid),
        .ret_reg(ret_reg), .ret_target(ret_target), .csr_we(csr_we),
        .csr_sel(csr_sel), .csr_wdata(csr_wdata), .irq_set(irq_set),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
        .csr_ie(csr_ie), .csr_ip(csr_ip), .csr_eba(csr_eba), .csr_deba(csr_deba)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_brk = 0; req_unmapped = 0; req_misalign = 0; req_scall = 0;
        div_valid = 0; div_divisor = 0; fault_pc = 0;
        ret_valid = 0; ret_reg = 0; ret_target = 0;
        csr_we = 0; csr_sel = 0; csr_wdata = 0; irq_set = 0;
    endtask

    task automatic csr_write(input logic [1:0] sel, input logic [31:0] data);
        csr_we = 1; csr_sel = sel; csr_wdata = data;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        rst = 1;
        idle_inputs();
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        chk("R1 ie", 32'(csr_ie), 0);
        chk("R1 ip", 32'(csr_ip), 0);
        chk("R1 eba", csr_eba, 0);
        chk("R1 deba", csr_deba, 0);
        chk("R1 redirect", 32'(redirect_valid), 0);
        chk("R1 gpr_we", 32'(gpr_we), 0);
    endtask

    localparam logic [31:0] EBA_V  = 32'h1234_5600;
    localparam logic [31:0] DEBA_V = 32'hABCD_EF00;

    initial begin
        do_reset();

        // R10: base writes, low byte forced to zero
        csr_write(2'd2, 32'h1234_56AB);
        chk("R10 eba", csr_eba, EBA_V);
        csr_write(2'd3, 32'hABCD_EFFF);
        chk("R10 deba", csr_deba, DEBA_V);

        // R2..R7, R11, R12, R14: sweep of all source combinations
        for (int e0 = 0; e0 < 2; e0++) begin
            for (int m = 0; m < 32; m++) begin
                logic [2:0]  ie_set;
                int          id;
                logic [31:0] pc;
                ie_set = 3'b110 | 3'(e0);
                csr_write(2'd0, 32'(ie_set));
                chk("R10 ie write", 32'(csr_ie), 32'(ie_set));
                pc = 32'h1000 + 32'(m) * 4 + 32'(e0) * 32'h100;
                req_brk      = m[0];
                req_unmapped = m[1];
                req_misalign = m[2];
                req_scall    = m[4];
                div_valid    = m[3] | m[0];
                div_divisor  = m[3] ? 32'd0 : 32'(m + 1);
                fault_pc     = pc;
                @(negedge clk);
                idle_inputs();
                if (m[0])                id = 1;
                else if (m[1] || m[2])   id = 4;
                else if (m[3])           id = 5;
                else if (m[4])           id = 7;
                else                     id = 0;
                if (id == 0) begin
                    chk("R11 no redirect", 32'(redirect_valid), 0);
                    chk("R11 no write", 32'(gpr_we), 0);
                    chk("R11 ie kept", 32'(csr_ie), 32'(ie_set));
                end else begin
                    chk("R14 redirect", 32'(redirect_valid), 1);
                    chk("R2 gpr_we", 32'(gpr_we), 1);
                    chk("R2 link pc", gpr_wdata, pc);
                    if (id == 1) begin
                        chk("R3 link reg", 32'(gpr_waddr), 31);
                        chk("R6 brk vector", redirect_pc, DEBA_V + 32);
                        chk("R5 ie", 32'(csr_ie), 32'({3'(e0), 2'b00}));
                    end else begin
                        chk("R2 link reg", 32'(gpr_waddr), 30);
                        chk("R7 R12 vector", redirect_pc, EBA_V + 32'(id) * 32);
                        chk("R4 ie", 32'(csr_ie), 32'({1'b0, 1'(e0), 1'b0}));
                    end
                end
                @(negedge clk);
                chk("R14 pulse ends", 32'(redirect_valid), 0);
            end
        end

        // R11: nonzero divisor alone
        div_valid = 1; div_divisor = 32'd7; fault_pc = 32'h40;
        @(negedge clk);
        idle_inputs();
        chk("R11 nonzero divisor", 32'({redirect_valid, gpr_we}), 0);

        // R8: returns through 29, 30, 31 for every enable word
        for (int v = 0; v < 8; v++) begin
            for (int r = 29; r < 32; r++) begin
                logic [2:0]  vv;
                logic [31:0] exp_ie;
                vv = 3'(v);
                csr_write(2'd0, 32'(vv));
                ret_valid = 1; ret_reg = 5'(r); ret_target = 32'h2000 + 32'(v * 16 + r);
                @(negedge clk);
                idle_inputs();
                if (r == 30)      exp_ie = 32'(vv[1]);
                else if (r == 31) exp_ie = 32'(vv[2]);
                else              exp_ie = 32'(vv);
                chk("R8 ret redirect", 32'(redirect_valid), 1);
                chk("R8 ret target", redirect_pc, 32'h2000 + 32'(v * 16 + r));
                chk("R8 ret no write", 32'(gpr_we), 0);
                chk("R8 ret ie", 32'(csr_ie), exp_ie);
            end
        end

        // R9: pending bits
        irq_set = 8'hFF;
        @(negedge clk);
        idle_inputs();
        chk("R9 set", 32'(csr_ip), 32'hFF);
        csr_write(2'd1, 32'hA5);
        chk("R9 w1c", 32'(csr_ip), 32'h5A);
        csr_write(2'd1, 32'h00);
        chk("R9 zero write", 32'(csr_ip), 32'h5A);
        irq_set = 8'h01; csr_we = 1; csr_sel = 2'd1; csr_wdata = 32'h03;
        @(negedge clk);
        idle_inputs();
        chk("R9 set wins", 32'(csr_ip), 32'h59);

        // R13: collisions
        csr_write(2'd0, 32'd1);
        req_scall = 1; fault_pc = 32'h300;
        ret_valid = 1; ret_reg = 5'd30; ret_target = 32'h9999;
        csr_we = 1; csr_sel = 2'd0; csr_wdata = 32'd7;
        @(negedge clk);
        idle_inputs();
        chk("R13 trap beats return", redirect_pc, EBA_V + 32'd224);
        chk("R13 ie write ignored", 32'(csr_ie), 32'd2);
        chk("R13 link", gpr_wdata, 32'h300);
        csr_write(2'd0, 32'd4);
        ret_valid = 1; ret_reg = 5'd31; ret_target = 32'h500;
        csr_we = 1; csr_sel = 2'd0; csr_wdata = 32'd6;
        @(negedge clk);
        idle_inputs();
        chk("R13 return beats ie write", 32'(csr_ie), 32'd1);

        // R1: reset after activity
        do_reset();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule